// File: doc/BRIEF.md
# Eight-Bank Open-Row Tracker

This block follows the open or closed condition of every bank in a DDR SDRAM device by watching the command stream that a controller issues. Each cycle it takes one command code, a bank number and a row address. Every bank keeps a short shift history of its open or closed condition, plus the row that the last activate latched into it. A bank counts as fully open only after its history has filled with ones. Because an activate inserts one 1 and the steps that follow repeat it, a bank must wait a few cycles after an activate before it may take a read or a write. Closing a bank drains the history back to zeros in the same gradual way.

The tracker also checks the commands against that history. A read or a write to a bank that is not fully open is a protocol violation. So is a calibration command issued while any bank is not fully closed. Either case gives a one-cycle error pulse in the cycle after the command, together with the number of the offending bank. The block sits beside a controller or a bus monitor as a passive observer and never alters the command stream.

Top module: `bank_row_tracker`

## Requirements
- R1: While rst_n is low, and right after it is released, every bank history reads 3'b000, every latched row reads 0, err_o is 0 and err_bank_o is 0.
- R2: Command code 3'd1 (activate) updates the addressed bank in the next cycle: its history becomes {old[1:0],1} and its row becomes addr_i. Every other bank takes a hold-step as defined in R5.
- R3: Command code 3'd2 (precharge) with addr_i bit 6 clear updates only the addressed bank: its history becomes {old[1:0],0}. Every other bank takes a hold-step.
- R4: Command code 3'd2 with addr_i bit 6 set updates every bank's history to {old[1:0],0}.
- R5: A hold-step turns a history into {old[1:0],old[0]}, so the newest bit is repeated. Command code 3'd0 (idle) applies a hold-step to every bank. No hold-step changes a latched row.
- R6: Command codes 3'd3 (read), 3'd4 (write), 3'd5 (calibrate), 3'd6 (refresh) and 3'd7 (mode set) leave every history and every latched row unchanged.
- R7: A read or a write whose addressed bank does not have history 3'b111 sets err_o high for the next cycle, with err_bank_o equal to that bank number. A read or a write to a bank with history 3'b111 gives no error.
- R8: A calibrate command while any bank's history is not 3'b000 sets err_o for the next cycle, with err_bank_o equal to the lowest-numbered such bank. With every bank closed, it gives no error.
- R9: A command that breaks neither rule leaves err_o at 0 and err_bank_o at 0 in the next cycle, so each violation gives a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command code for this cycle (codes as in R2 to R6) |
| bank_i | input | 3 | Bank addressed by the command |
| addr_i | input | 15 | Row address; bit 6 selects all banks on a precharge |
| bank_state_o | output | 24 | Bank histories, bank n in bits [3n+2:3n] |
| bank_row_o | output | 120 | Latched rows, bank n in bits [15n+14:15n] |
| err_o | output | 1 | One-cycle violation pulse |
| err_bank_o | output | 3 | Bank that caused the violation, 0 when none |

## Verification
The bench builds the tracker with its default values: eight banks, 15-bit rows and bit 6 as the all-banks select. With only eight 3-bit histories, a full sweep over every command code, every bank and both values of the select bit is cheap. The bench runs that sweep from several different history patterns, and then a long pseudo-random stream in which the histories pass through their intermediate values. A model in the bench computes each history from the shift rules. It compares every history, every latched row and the error outputs after each command, so that partly open banks, late reads and calibration with one lingering bank are all covered.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_OPEN  = 3'd1,
      CMD_CLOSE = 3'd2,
      CMD_RD    = 3'd3,
      CMD_WR    = 3'd4,
      CMD_CAL   = 3'd5,
      CMD_REF   = 3'd6,
      CMD_MODE  = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_NOP   = 2'd1,
      STEP_OPEN  = 2'd2,
      STEP_CLOSE = 2'd3
   } step_e;

   localparam int          HIST_W     = 3;
   localparam logic [2:0]  HIST_OPEN  = 3'b111;
   localparam logic [2:0]  HIST_SHUT  = 3'b000;
   localparam logic [2:0]  CLOSE_MASK = 3'b110;

endpackage

// File: rtl/bank_step_dec.sv
module bank_step_dec
   import bank_trk_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 15,
   parameter int ALL_BIT   = 6,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic [2:0]             cmd_i,
   input  logic [BANK_W-1:0]      bank_i,
   input  logic [ROW_W-1:0]       addr_i,
   output logic [2*NUM_BANKS-1:0] step_o
);

   cmd_e cmd;
   assign cmd = cmd_e'(cmd_i);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      logic  sel;
      step_e st;
      assign sel = (bank_i == BANK_W'(b));
      always_comb begin
         unique case (cmd)
            CMD_IDLE:  st = STEP_NOP;
            CMD_OPEN:  st = sel ? STEP_OPEN : STEP_NOP;
            CMD_CLOSE: st = (sel || addr_i[ALL_BIT]) ? STEP_CLOSE : STEP_NOP;
            default:   st = STEP_HOLD;
         endcase
      end
      assign step_o[2*b +: 2] = st;
   end

endmodule

// File: rtl/bank_slot.sv
module bank_slot
   import bank_trk_pkg::*;
#(
   parameter int ROW_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step_i,
   input  logic [ROW_W-1:0]  row_i,
   output logic [HIST_W-1:0] hist_o,
   output logic [ROW_W-1:0]  row_o
);

   logic [HIST_W-1:0] hist_q;
   logic [ROW_W-1:0]  row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= HIST_SHUT;
         row_q  <= '0;
      end else begin
         unique case (step_i)
            STEP_OPEN: begin
               hist_q <= {hist_q[HIST_W-2:0], 1'b1};
               row_q  <= row_i;
            end
            STEP_CLOSE: hist_q <= {hist_q[HIST_W-2:0], 1'b0} & CLOSE_MASK;
            STEP_NOP:   hist_q <= {hist_q[HIST_W-2:0], hist_q[0]};
            default:    ;
         endcase
      end
   end

   assign hist_o = hist_q;
   assign row_o  = row_q;

   // R2: an activate step shifts in a one and captures the row
   a_r2_open_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_OPEN |=> hist_q[0] && hist_q[2:1] == $past(hist_q[1:0])
                              && row_q == $past(row_i));
   // R3 and R4: a close step shifts in a zero and keeps the row
   a_r3_close_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_CLOSE |=> !hist_q[0] && hist_q[2:1] == $past(hist_q[1:0])
                               && $stable(row_q));
   // R5: a hold-step repeats the newest bit
   a_r5_nop_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_NOP |=> hist_q == {$past(hist_q[1:0]), $past(hist_q[0])}
                             && $stable(row_q));
   // R6: other commands freeze the bank
   a_r6_hold_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_HOLD |=> $stable(hist_q) && $stable(row_q));

endmodule

// File: rtl/bank_rule_chk.sv
module bank_rule_chk
   import bank_trk_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  cmd_i,
   input  logic [BANK_W-1:0]           bank_i,
   input  logic [HIST_W*NUM_BANKS-1:0] hist_i,
   output logic                        err_o,
   output logic [BANK_W-1:0]           err_bank_o
);

   cmd_e              cmd;
   logic              is_rw;
   logic [HIST_W-1:0] tgt_hist;
   logic              rw_bad;
   logic              cal_bad;
   logic [BANK_W-1:0] cal_bank;
   logic              err_q;
   logic [BANK_W-1:0] err_bank_q;

   assign cmd      = cmd_e'(cmd_i);
   assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign tgt_hist = hist_i[HIST_W*bank_i +: HIST_W];
   assign rw_bad   = is_rw && (tgt_hist != HIST_OPEN);

   // lowest bank that is not fully closed: scan from the top down
   always_comb begin
      cal_bad  = 1'b0;
      cal_bank = '0;
      for (int b = NUM_BANKS-1; b >= 0; b--) begin
         if (hist_i[HIST_W*b +: HIST_W] != HIST_SHUT) begin
            cal_bad  = 1'b1;
            cal_bank = BANK_W'(b);
         end
      end
      cal_bad = cal_bad && (cmd == CMD_CAL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q      <= 1'b0;
         err_bank_q <= '0;
      end else begin
         err_q      <= rw_bad || cal_bad;
         err_bank_q <= rw_bad ? bank_i : (cal_bad ? cal_bank : '0);
      end
   end

   assign err_o      = err_q;
   assign err_bank_o = err_bank_q;

   // R7: access to a bank that is not fully open
   a_r7_rw_violation: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw && hist_i[HIST_W*bank_i +: HIST_W] != HIST_OPEN
      |=> err_o && err_bank_o == $past(bank_i));
   // R8: calibration with a bank still open
   a_r8_cal_violation: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_CAL && hist_i != '0 |=> err_o);
   // R9: commands outside the rules never raise an error
   a_r9_no_false_error: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rw && cmd != CMD_CAL |=> !err_o && err_bank_o == '0);

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
   import bank_trk_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 15,
   parameter int ALL_BIT   = 6,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  cmd_i,
   input  logic [BANK_W-1:0]           bank_i,
   input  logic [ROW_W-1:0]            addr_i,
   output logic [HIST_W*NUM_BANKS-1:0] bank_state_o,
   output logic [ROW_W*NUM_BANKS-1:0]  bank_row_o,
   output logic                        err_o,
   output logic [BANK_W-1:0]           err_bank_o
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS-1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (ALL_BIT >= ROW_W) begin : g_bad_allbit
      $error("ALL_BIT must index a bit of the row address");
   end

   logic [2*NUM_BANKS-1:0] steps;

   bank_step_dec #(
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W),
      .ALL_BIT   (ALL_BIT)
   ) dec_i (
      .cmd_i  (cmd_i),
      .bank_i (bank_i),
      .addr_i (addr_i),
      .step_o (steps)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_slot #(.ROW_W(ROW_W)) slot_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .step_i (step_e'(steps[2*b +: 2])),
         .row_i  (addr_i),
         .hist_o (bank_state_o[HIST_W*b +: HIST_W]),
         .row_o  (bank_row_o[ROW_W*b +: ROW_W])
      );
   end

   bank_rule_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd_i),
      .bank_i     (bank_i),
      .hist_i     (bank_state_o),
      .err_o      (err_o),
      .err_bank_o (err_bank_o)
   );

endmodule

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB   = 8;
   localparam int RW   = 15;
   localparam int BW   = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    cmd_i;
   logic [BW-1:0] bank_i;
   logic [RW-1:0] addr_i;
   logic [3*NB-1:0]  bank_state_o;
   logic [RW*NB-1:0] bank_row_o;
   logic          err_o;
   logic [BW-1:0] err_bank_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   logic [2:0]    exp_st  [NB];
   logic [RW-1:0] exp_row [NB];
   logic          exp_err;
   logic [BW-1:0] exp_eb;
   logic [31:0]   lf = 32'h1ACE_5EED;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .ALL_BIT(6)) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .bank_i (bank_i),
      .addr_i (addr_i), .bank_state_o (bank_state_o), .bank_row_o (bank_row_o),
      .err_o (err_o), .err_bank_o (err_bank_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] got, input logic [127:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic compare(input logic [2:0] c, input logic a6);
      logic [3*NB-1:0]  es;
      logic [RW*NB-1:0] er;
      string sreq, rreq, ereq;
      for (int i = 0; i < NB; i++) begin
         es[3*i +: 3]   = exp_st[i];
         er[RW*i +: RW] = exp_row[i];
      end
      case (c)
         3'd0: sreq = "R5";
         3'd1: sreq = "R2";
         3'd2: sreq = a6 ? "R4" : "R3";
         default: sreq = "R6";
      endcase
      rreq = (c == 3'd1) ? "R2" : "R6";
      ereq = (c == 3'd3 || c == 3'd4) ? "R7" : ((c == 3'd5) ? "R8" : "R9");
      chk(sreq, "bank histories", 128'(bank_state_o), 128'(es));
      chk(rreq, "latched rows", 128'(bank_row_o), 128'(er));
      chk(ereq, "error pulse", 128'(err_o), 128'(exp_err));
      chk(ereq, "error bank", 128'(err_bank_o), 128'(exp_eb));
   endtask

   task automatic issue(input logic [2:0] c, input int b, input logic [RW-1:0] a);
      exp_err = 1'b0;
      exp_eb  = '0;
      if ((c == 3'd3 || c == 3'd4) && exp_st[b] != 3'b111) begin
         exp_err = 1'b1; exp_eb = BW'(b);
      end
      if (c == 3'd5) begin
         for (int i = NB-1; i >= 0; i--)
            if (exp_st[i] != 3'b000) begin exp_err = 1'b1; exp_eb = BW'(i); end
      end
      for (int i = 0; i < NB; i++) begin
         case (c)
            3'd0: exp_st[i] = {exp_st[i][1:0], exp_st[i][0]};
            3'd1: if (i == b) begin
                     exp_st[i] = {exp_st[i][1:0], 1'b1}; exp_row[i] = a;
                  end else exp_st[i] = {exp_st[i][1:0], exp_st[i][0]};
            3'd2: if (i == b || a[6]) exp_st[i] = {exp_st[i][1:0], 1'b0};
                  else exp_st[i] = {exp_st[i][1:0], exp_st[i][0]};
            default: ;
         endcase
      end
      cmd_i = c; bank_i = BW'(b); addr_i = a;
      @(negedge clk);
      compare(c, a[6]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; cmd_i = 3'd1; bank_i = '0; addr_i = 15'h7FFF;
      for (int i = 0; i < NB; i++) begin exp_st[i] = 3'b000; exp_row[i] = '0; end
      exp_err = 1'b0; exp_eb = '0;
      repeat (3) @(negedge clk);
      // R1: reset values, even with an activate on the inputs
      chk("R1", "histories in reset", 128'(bank_state_o), 128'(0));
      chk("R1", "rows in reset", 128'(bank_row_o), 128'(0));
      chk("R1", "error in reset", 128'({err_o, err_bank_o}), 128'(0));
      cmd_i = 3'd0;
      rst_n = 1'b1;
      chk("R1", "histories after release", 128'(bank_state_o), 128'(0));

      // directed: R7 early access, then legal access once open
      issue(3'd1, 3, 15'h1234);
      issue(3'd3, 3, 15'h0);
      issue(3'd0, 0, 15'h0);
      issue(3'd0, 0, 15'h0);
      issue(3'd4, 3, 15'h0);
      issue(3'd3, 2, 15'h0);
      // R8: calibration with bank 3 open, then after a full close
      issue(3'd5, 0, 15'h0);
      issue(3'd2, 3, 15'h0000);
      issue(3'd0, 0, 15'h0);
      issue(3'd5, 0, 15'h0);
      issue(3'd0, 0, 15'h0);
      issue(3'd5, 0, 15'h0);
      // R4: all-bank close with bit 6
      issue(3'd1, 0, 15'h0ABC);
      issue(3'd1, 5, 15'h7001);
      issue(3'd2, 2, 15'h0040);
      issue(3'd0, 0, 15'h0);
      issue(3'd0, 0, 15'h0);
      issue(3'd5, 0, 15'h0);

      // exhaustive sweep over codes, banks and the all-bank bit, four passes
      for (int pass = 0; pass < 4; pass++)
         for (int c = 0; c < 8; c++)
            for (int b = 0; b < NB; b++)
               for (int s = 0; s < 2; s++)
                  issue(3'(c), b, 15'((b * 977 + c * 131 + pass) & 16'h7FBF) | (15'(s) << 6));

      // pseudo-random stream, activates weighted up
      for (int k = 0; k < 3000; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         issue(lf[4] ? 3'd1 : lf[2:0], int'(lf[7:5]), lf[22:8]);
      end
      finish_run();
   end

endmodule